// File: doc/BRIEF.md
# Three-Operand Min / Max / Median Selector

This unit takes three 32-bit source words, uses the low 16 bits of each as an operand, and returns the smallest, the largest or the middle of the three. A 9-bit opcode picks both the operation and how the operands are read: as unsigned integers, as two's-complement integers, or as IEEE half-precision floats. The answer is zero-extended to 32 bits and registered, so it appears one clock after the request strobe.

For floats, a NaN operand is removed by position: the first NaN found, checking source 0, then 1, then 2, is dropped. The two remaining operands then go to a two-input minimum or maximum. A median that has lost an operand this way becomes a minimum. Integer and NaN-free float selections follow fixed strict-comparison rules. When operands compare equal, these rules favour particular operands, and for float zeros of opposite sign that choice shows in the returned bits.

Top module: `tri_select_unit`

## Requirements
- R1: Opcodes: 0x1f4 half min, 0x1f5 signed min, 0x1f6 unsigned min, 0x1f7 half max, 0x1f8 signed max, 0x1f9 unsigned max, 0x1fa half median, 0x1fb signed median, 0x1fc unsigned median.
- R2: Only bits 15:0 of each source are used; bits 31:16 have no effect on the result. Unsigned opcodes compare those bits as unsigned numbers.
- R3: Signed opcodes compare bits 15:0 as two's-complement values, so 0x8000 is the smallest value and 0x7fff the largest.
- R4: Minimum returns source 2 only when it is strictly below both source 0 and source 1. Otherwise it returns the smaller of source 0 and source 1, and source 0 when those two are equal.
- R5: Maximum returns source 2 only when it is strictly above both source 0 and source 1. Otherwise it returns the larger of source 0 and source 1, and source 0 when those two are equal.
- R6: Median returns source 2 if it lies strictly between source 0 and source 1. Failing that, it returns source 1 if that lies strictly between source 0 and source 2. Failing both, it returns source 0.
- R7: In half precision, -0 (0x8000) and +0 (0x0000) compare equal, and infinities order normally. A value is NaN only when bits 14:10 are all ones and bits 9:0 are nonzero.
- R8: In half precision, NaNs are tested in the order source 0, 1, 2. The first NaN found is dropped and the other two go to a two-input min, or max for the max opcode. A median with a NaN uses the two-input min. In that two-input step, the lower-numbered operand wins a tie.
- R9: If exactly two half operands are NaN, the result is the third operand. If all three are NaN, the result is 0x7E00.
- R10: result[31:16] is always zero. out_valid is high in exactly the cycle after the cycle in which in_valid was sampled high. result changes only in that cycle.
- R11: An opcode outside 0x1f4..0x1fc, when accepted, gives result 0 with illegal_op high for that one output cycle. illegal_op is low otherwise.
- R12: A synchronous active-low reset clears out_valid, illegal_op and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe; inputs are sampled when high |
| opcode | input | 9 | Operation and number type selector |
| src0 | input | 32 | Source word 0 (operand in bits 15:0) |
| src1 | input | 32 | Source word 1 (operand in bits 15:0) |
| src2 | input | 32 | Source word 2 (operand in bits 15:0) |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 32 | Selected operand, zero-extended |
| illegal_op | output | 1 | Unsupported opcode was accepted |

## Verification
Every answer, including the illegal-opcode flag, is due exactly one rising edge after the edge that accepted the request. The driver pushes an expected item for each request it drives. The monitor pops one item per cycle in which out_valid is high and compares it on the falling edge that follows, so back-to-back requests are matched in order with no extra offset. After an idle cycle the bench also confirms that out_valid has dropped. Expected values come from a reference model that converts half-precision operands to real numbers and applies the stated tie and NaN rules.

// File: rtl/tri_sel_pkg.sv
// Package: shared types and constants for the three-operand selector.
// Assumes half precision uses the 1/5/10 sign/exponent/mantissa split.
package tri_sel_pkg;
    typedef enum logic [1:0] {SEL_MIN = 2'd0, SEL_MAX = 2'd1, SEL_MED = 2'd2} sel_kind_e;
    typedef enum logic [1:0] {NUM_HALF = 2'd0, NUM_SINT = 2'd1, NUM_UINT = 2'd2} num_kind_e;

    localparam int OPER_W     = 16;
    localparam int HALF_EXP_W = 5;
    localparam int HALF_MAN_W = 10;
    localparam logic [OPER_W-1:0] HALF_QNAN = 16'h7E00;
    localparam int OPC_W      = 9;
    localparam logic [OPC_W-1:0] OPC_BASE = 9'h1f4;
    localparam int OPC_COUNT  = 9;
endpackage

// File: rtl/tri_sel_decode.sv
// Module: opcode decoder. Maps the nine supported codes, which run in groups
// of three (half, signed, unsigned) for min, max and median, onto an
// operation kind and number kind. Assumes nothing about opcode stability.
module tri_sel_decode
    import tri_sel_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output sel_kind_e        kind,
    output num_kind_e        num,
    output logic             legal
);
    logic [OPC_W-1:0] offset;

    // Offset of the opcode within the supported window.
    always_comb offset = opcode - OPC_BASE;

    // Range check plus split of the offset into operation and type.
    always_comb begin
        legal = (opcode >= OPC_BASE) && (offset < OPC_W'(OPC_COUNT));
        kind  = SEL_MIN;
        num   = NUM_UINT;
        if (legal) begin
            case (offset / OPC_W'(3))
                OPC_W'(0): kind = SEL_MIN;
                OPC_W'(1): kind = SEL_MAX;
                default:   kind = SEL_MED;
            endcase
            case (offset % OPC_W'(3))
                OPC_W'(0): num = NUM_HALF;
                OPC_W'(1): num = NUM_SINT;
                default:   num = NUM_UINT;
            endcase
        end
    end
endmodule

// File: rtl/tri_sel_key.sv
// Module: ordering-key generator for one operand. Produces a key whose
// unsigned order equals the operand order for the chosen number kind, and
// a NaN flag (half kind only). Assumes -0 and +0 must map to one key.
module tri_sel_key
    import tri_sel_pkg::*;
(
    input  logic [OPER_W-1:0] value,
    input  num_kind_e         num,
    output logic [OPER_W-1:0] key,
    output logic              is_nan
);
    localparam logic [OPER_W-1:0] SIGN_BIT = OPER_W'(1) << (OPER_W-1);

    logic [HALF_EXP_W-1:0] expo;
    logic [HALF_MAN_W-1:0] mant;
    logic [OPER_W-1:0]     canon;

    // Field extraction and zero canonicalisation for the float view.
    always_comb begin
        expo  = value[HALF_MAN_W +: HALF_EXP_W];
        mant  = value[HALF_MAN_W-1:0];
        canon = (value == SIGN_BIT) ? '0 : value;
    end

    // Key mapping per number kind.
    always_comb begin
        is_nan = 1'b0;
        case (num)
            NUM_UINT: key = value;
            NUM_SINT: key = value ^ SIGN_BIT;
            default: begin
                is_nan = (&expo) && (|mant);
                key    = canon[OPER_W-1] ? ~canon : (canon | SIGN_BIT);
            end
        endcase
    end
endmodule

// File: rtl/tri_sel_core.sv
// Module: combinational selection. Applies NaN dropping by position, then
// the strict min/max/median rules on ordering keys. Assumes NaN flags are
// only ever set for half-precision operands.
module tri_sel_core
    import tri_sel_pkg::*;
(
    input  sel_kind_e         kind,
    input  logic [OPER_W-1:0] v0,
    input  logic [OPER_W-1:0] v1,
    input  logic [OPER_W-1:0] v2,
    input  logic [OPER_W-1:0] k0,
    input  logic [OPER_W-1:0] k1,
    input  logic [OPER_W-1:0] k2,
    input  logic              n0,
    input  logic              n1,
    input  logic              n2,
    output logic [OPER_W-1:0] pick
);
    // Two-operand min/max that skips a NaN; x wins ties.
    function automatic logic [OPER_W-1:0] pair_sel(
        input logic [OPER_W-1:0] xv, input logic [OPER_W-1:0] xk, input logic xn,
        input logic [OPER_W-1:0] yv, input logic [OPER_W-1:0] yk, input logic yn,
        input logic want_max);
        logic [OPER_W-1:0] r;
        if (xn && yn)      r = HALF_QNAN;
        else if (xn)       r = yv;
        else if (yn)       r = xv;
        else if (want_max) r = (yk > xk) ? yv : xv;
        else               r = (yk < xk) ? yv : xv;
        return r;
    endfunction

    logic              is_max;
    logic [OPER_W-1:0] base01;
    logic              mid2, mid1;

    // Shared terms of the strict three-operand rules.
    always_comb begin
        is_max = (kind == SEL_MAX);
        base01 = pair_sel(v0, k0, 1'b0, v1, k1, 1'b0, is_max);
        mid2   = ((k2 > k1) && (k2 < k0)) || ((k2 < k1) && (k2 > k0));
        mid1   = ((k1 > k2) && (k1 < k0)) || ((k1 < k2) && (k1 > k0));
    end

    // Final choice: NaN path first, then operation rules.
    always_comb begin
        if (n0 && n1 && n2)
            pick = HALF_QNAN;
        else if (n0)
            pick = pair_sel(v1, k1, n1, v2, k2, n2, is_max);
        else if (n1)
            pick = pair_sel(v0, k0, n0, v2, k2, n2, is_max);
        else if (n2)
            pick = pair_sel(v0, k0, n0, v1, k1, n1, is_max);
        else begin
            case (kind)
                SEL_MIN: pick = ((k2 < k0) && (k2 < k1)) ? v2 : base01;
                SEL_MAX: pick = ((k2 > k0) && (k2 > k1)) ? v2 : base01;
                default: pick = mid2 ? v2 : (mid1 ? v1 : v0);
            endcase
        end
    end
endmodule

// File: rtl/tri_select_unit.sv
// Module: top of the three-operand selector. Decodes the opcode, builds
// ordering keys for the three low halves, selects, and registers the
// zero-extended answer with a one-cycle valid. Assumes sources are stable
// only in the cycle in_valid is high.
module tri_select_unit
    import tri_sel_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [DATA_W-1:0] src0,
    input  logic [DATA_W-1:0] src1,
    input  logic [DATA_W-1:0] src2,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              illegal_op
);
    localparam int NUM_SRC = 3;

    sel_kind_e         kind;
    num_kind_e         num;
    logic              legal;
    logic [OPER_W-1:0] opnd [NUM_SRC];
    logic [OPER_W-1:0] key  [NUM_SRC];
    logic [NUM_SRC-1:0] nan;
    logic [OPER_W-1:0] pick;

    tri_sel_decode u_dec (
        .opcode (opcode),
        .kind   (kind),
        .num    (num),
        .legal  (legal)
    );

    // Low-half operand extraction.
    always_comb begin
        opnd[0] = src0[OPER_W-1:0];
        opnd[1] = src1[OPER_W-1:0];
        opnd[2] = src2[OPER_W-1:0];
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_key
        tri_sel_key u_key (
            .value  (opnd[i]),
            .num    (num),
            .key    (key[i]),
            .is_nan (nan[i])
        );
    end

    tri_sel_core u_core (
        .kind (kind),
        .v0   (opnd[0]), .v1 (opnd[1]), .v2 (opnd[2]),
        .k0   (key[0]),  .k1 (key[1]),  .k2 (key[2]),
        .n0   (nan[0]),  .n1 (nan[1]),  .n2 (nan[2]),
        .pick (pick)
    );

    // Output register: result, valid and illegal strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            illegal_op <= 1'b0;
            result     <= '0;
        end else begin
            out_valid  <= in_valid;
            illegal_op <= in_valid && !legal;
            if (in_valid)
                result <= legal ? {{(DATA_W-OPER_W){1'b0}}, pick} : '0;
        end
    end

    // R10: valid strobe follows the request by exactly one cycle.
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r10_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R10: upper half of the result is never set.
    a_r10_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        result[DATA_W-1:OPER_W] == '0);
    // R10: result holds while no answer is presented.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    // R11: illegal flag comes with a valid strobe and a zero result.
    a_r11_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> (out_valid && result == '0));
    // R1: codes outside the window are flagged one cycle later.
    a_r1_out_of_window: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opcode < OPC_BASE || opcode > OPC_BASE + OPC_W'(OPC_COUNT - 1)))
        |=> illegal_op);
    // R4: integer answers are always one of the three low halves.
    a_r4_from_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && legal && num != NUM_HALF) |=>
        (result[OPER_W-1:0] == $past(src0[OPER_W-1:0]) ||
         result[OPER_W-1:0] == $past(src1[OPER_W-1:0]) ||
         result[OPER_W-1:0] == $past(src2[OPER_W-1:0])));
    // R12: reset clears the strobes.
    a_r12_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !illegal_op && result == '0));
endmodule

// File: tb/sim_tri_select_unit.sv
module sim_tri_select_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [8:0]  opcode = '0;
    logic [31:0] src0 = '0, src1 = '0, src2 = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        illegal_op;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    typedef struct {
        logic [31:0] res;
        logic        ill;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    tri_select_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .src0(src0), .src1(src1), .src2(src2),
        .out_valid(out_valid), .result(result), .illegal_op(illegal_op)
    );

    // ---------------- reference model (from the requirements) ----------------
    function automatic bit h_nan(input logic [15:0] h);
        return (h[14:10] == 5'h1f) && (h[9:0] != 0);
    endfunction

    function automatic real h_val(input logic [15:0] h);
        real m, r;
        int e;
        e = int'(h[14:10]);
        if (e == 31) m = 1.0e30;
        else if (e == 0) begin
            m = real'(h[9:0]);
            for (int i = 0; i < 24; i++) m = m / 2.0;
        end else begin
            m = real'(1024 + int'(h[9:0]));
            for (int i = 0; i < 25; i++) m = m / 2.0;
            for (int i = 0; i < e; i++) m = m * 2.0;
        end
        r = h[15] ? -m : m;
        return r;
    endfunction

    function automatic real num_val(input int typ, input logic [15:0] x);
        if (typ == 0) return h_val(x);
        if (typ == 1) return real'(int'($signed(x)));
        return real'(int'(x));
    endfunction

    // kind: 0 min, 1 max, 2 median; typ: 0 half, 1 signed, 2 unsigned
    function automatic logic [15:0] ref_two(input int kind, input int typ,
                                            input logic [15:0] x, input logic [15:0] y);
        bit xn, yn;
        xn = (typ == 0) && h_nan(x);
        yn = (typ == 0) && h_nan(y);
        if (xn && yn) return 16'h7E00;
        if (xn) return y;
        if (yn) return x;
        if (kind == 1) return (num_val(typ, y) > num_val(typ, x)) ? y : x;
        return (num_val(typ, y) < num_val(typ, x)) ? y : x;
    endfunction

    function automatic logic [15:0] ref_three(input int kind, input int typ,
            input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
        real va, vb, vc;
        if (typ == 0) begin
            if (h_nan(a) && h_nan(b) && h_nan(c)) return 16'h7E00;
            if (h_nan(a)) return ref_two(kind == 1 ? 1 : 0, typ, b, c);
            if (h_nan(b)) return ref_two(kind == 1 ? 1 : 0, typ, a, c);
            if (h_nan(c)) return ref_two(kind == 1 ? 1 : 0, typ, a, b);
        end
        va = num_val(typ, a); vb = num_val(typ, b); vc = num_val(typ, c);
        if (kind == 0) return (vc < va && vc < vb) ? c : ref_two(0, typ, a, b);
        if (kind == 1) return (vc > va && vc > vb) ? c : ref_two(1, typ, a, b);
        if ((vc > vb && vc < va) || (vc < vb && vc > va)) return c;
        if ((vb > vc && vb < va) || (vb < vc && vb > va)) return b;
        return a;
    endfunction

    // ---------------- driver ----------------
    task automatic apply(input logic [8:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] c, input string tag);
        exp_t e;
        int kind, typ;
        @(negedge clk);
        opcode = op; src0 = a; src1 = b; src2 = c; in_valid = 1'b1;
        if (op >= 9'h1f4 && op <= 9'h1fc) begin
            kind = int'(op - 9'h1f4) / 3;
            typ  = int'(op - 9'h1f4) % 3;
            e.res = {16'h0, ref_three(kind, typ, a[15:0], b[15:0], c[15:0])};
            e.ill = 1'b0;
        end else begin
            e.res = '0;
            e.ill = 1'b1;
        end
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10 unexpected out_valid", 32'(out_valid), 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(result == e.res, e.tag, result, e.res);
                check(illegal_op == e.ill, {e.tag, " illegal_op"}, 32'(illegal_op), 32'(e.ill));
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(out_valid == 0 && illegal_op == 0 && result == 0, "R12 reset state",
              {result[29:0], out_valid, illegal_op}, 32'h0);
        rst_n = 1'b1;

        // R1/R2 unsigned with junk upper bits
        apply(9'h1f6, 32'hFFFF_0005, 32'h1234_0003, 32'hABCD_0009, "R2 umin upper ignored");
        apply(9'h1f9, 32'hFFFF_0005, 32'h0000_8000, 32'h0001_0009, "R2 umax");
        apply(9'h1fc, 32'h0000_0005, 32'h0000_0003, 32'h0000_0009, "R6 umed");
        // R3 signed
        apply(9'h1f5, 32'h0000_7fff, 32'h0000_8000, 32'h0000_0001, "R3 smin");
        apply(9'h1f8, 32'h0000_7fff, 32'h0000_8000, 32'h0000_ffff, "R3 smax");
        apply(9'h1fb, 32'h0000_ffff, 32'h0000_8000, 32'h0000_0001, "R3 smed");
        // R4/R5 strict rule, ties
        apply(9'h1f6, 32'h0000_0004, 32'h0000_0004, 32'h0000_0004, "R4 umin all equal");
        apply(9'h1f9, 32'h0000_0002, 32'h0000_0007, 32'h0000_0007, "R5 umax tie with src2");
        // R6 median ties to src0
        apply(9'h1fc, 32'h0000_0003, 32'h0000_0003, 32'h0000_0001, "R6 umed tie");
        apply(9'h1fc, 32'h0000_0001, 32'h0000_0005, 32'h0000_0003, "R6 umed src2 between");
        // R7 half zeros and infinities
        apply(9'h1f4, 32'h0000_8000, 32'h0000_0000, 32'h0000_0000, "R7 hmin -0 tie -> src0");
        apply(9'h1f7, 32'h0000_0000, 32'h0000_8000, 32'h0000_8000, "R7 hmax +0 tie -> src0");
        apply(9'h1f4, 32'h0000_3c00, 32'h0000_fc00, 32'h0000_c000, "R7 hmin -inf");
        apply(9'h1f7, 32'h0000_3c00, 32'h0000_7c00, 32'h0000_c000, "R7 hmax +inf not NaN");
        apply(9'h1fa, 32'h0000_bc00, 32'h0000_4000, 32'h0000_3c00, "R6 hmed");
        // R8 NaN priority
        apply(9'h1f7, 32'h0000_7e00, 32'h0000_3c00, 32'h0000_4000, "R8 hmax nan src0");
        apply(9'h1f4, 32'h0000_3c00, 32'h0000_7c01, 32'h0000_4000, "R8 hmin nan src1");
        apply(9'h1fa, 32'h0000_4400, 32'h0000_4000, 32'h0000_fe00, "R8 hmed nan -> min");
        apply(9'h1fa, 32'h0000_7e00, 32'h0000_4400, 32'h0000_3c00, "R8 hmed nan src0");
        // R9 multiple NaNs
        apply(9'h1f4, 32'h0000_7e00, 32'h0000_ffff, 32'h0000_4000, "R9 two nans");
        apply(9'h1f7, 32'h0000_3c00, 32'h0000_7e01, 32'h0000_7c10, "R9 two nans b");
        apply(9'h1fa, 32'h0000_7e00, 32'h0000_7d00, 32'h0000_fc01, "R9 three nans");
        // R11 illegal opcodes
        apply(9'h1f3, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003, "R11 below window");
        apply(9'h1fd, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003, "R11 above window");
        apply(9'h1f6, 32'h0000_0009, 32'h0000_0002, 32'h0000_0003, "R11 legal after illegal");
        idle();
        @(negedge clk);
        // R10: no request -> no strobe
        check(out_valid == 0 && illegal_op == 0, "R10 idle out_valid",
              {30'h0, out_valid, illegal_op}, 32'h0);

        // Random mix, back to back
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a, b, c;
            logic [8:0] op;
            a = $urandom; b = $urandom; c = $urandom;
            if ($urandom_range(0, 3) == 0) a[15:0] = {a[15], 5'h1f, a[9:0]};
            if ($urandom_range(0, 3) == 0) b[15:0] = {b[15], 5'h1f, b[9:0]};
            if ($urandom_range(0, 3) == 0) c[15:0] = {c[15], 5'h1f, c[9:0]};
            if ($urandom_range(0, 5) == 0) b[15:0] = a[15:0];
            op = (i % 50 == 7) ? 9'(9'h1f0 + 9'($urandom_range(0, 3))) :
                                 9'(9'h1f4 + 9'($urandom_range(0, 8)));
            apply(op, a, b, c, "R1 random mix");
            if (i % 37 == 0) idle();
        end
        idle();
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R10 all results delivered", 32'(sb.size()), 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule